// File: doc/BRIEF.md
# Retriggerable Down-Counting Watchdog Timer

This block is a watchdog that a processor must service at regular intervals. It is built around a down counter that is 9 bits wide by default. The counter is loaded with an initial value taken from a static configuration input. It steps down by one on each cycle in which a clock-enable tick is high. When the count runs out, the block raises a one-cycle timeout pulse. Elsewhere on the chip this pulse drives the reset pulse generator and the programmable logic array. After the pulse the counter reloads and keeps running.

Start-up follows one of two modes, chosen by a static configuration input. In auto mode the watchdog starts by itself on the first cycle after the extended reset is released. In armed mode it waits for an enable pulse, which address decoding produces from a processor write. An enable pulse that arrives while extended reset is active is ignored. A clear pulse, also produced from a processor write, reloads the counter while it runs. A clear pulse that arrives before the watchdog has started does nothing. Synchronous system reset is handled the same way as extended reset.

Top module: `retrig_wdt`

## Requirements
- R1: While `rst` or `ext_rst_i` is high, the next cycle shows `running_o`=0, `timeout_o`=0 and `count_o` equal to `init_val_i`. An `arm_pulse_i` seen in such a cycle is ignored.
- R2: With `auto_start_i`=1, the first cycle in which `ext_rst_i` is sampled low after reset or extended reset makes `running_o`=1 on the next cycle, with `count_o` equal to `init_val_i`.
- R3: With `auto_start_i`=0, the release of extended reset leaves `running_o`=0, and `running_o` stays 0 until `arm_pulse_i` is sampled high. `running_o` is 1 on the cycle after that sample.
- R4: An `arm_pulse_i` sampled while `ext_rst_i` is high does not start the watchdog, even after `ext_rst_i` falls.
- R5: While running, each cycle with `tick_i`=1 lowers `count_o` by exactly one. A cycle with `tick_i`=0 leaves it unchanged. The count is `CNT_W` bits wide, so an initial value of 511 is held and decremented in full.
- R6: A tick sampled while `count_o` is 1 (or 0) sets `timeout_o`=1 for exactly the next cycle, reloads `count_o` with `init_val_i` and keeps `running_o`=1. The timeout therefore comes on the `init_val_i`-th tick after a load.
- R7: A `kick_pulse_i` sampled while running reloads `count_o` with `init_val_i` and produces no timeout, even if a tick that would have timed out arrives in the same cycle.
- R8: A `kick_pulse_i` sampled before the watchdog has started leaves `running_o`=0 and `count_o` unchanged.
- R9: An `arm_pulse_i` sampled while running has no effect: the count goes on decrementing and is not reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_i | input | 1 | Extended reset level; high holds the watchdog stopped |
| tick_i | input | 1 | Clock-enable tick that allows one decrement |
| auto_start_i | input | 1 | Static start mode: 1 = auto start, 0 = wait for arm pulse |
| arm_pulse_i | input | 1 | Decoded enable pulse from a processor write |
| kick_pulse_i | input | 1 | Decoded clear pulse from a processor write |
| init_val_i | input | CNT_W | Configured initial count |
| timeout_o | output | 1 | One-cycle timeout pulse |
| running_o | output | 1 | High while the watchdog is counting |
| count_o | output | CNT_W | Present counter value |

## Verification
The table walk uses auto mode with a small initial value. It mixes ticks, idle cycles, clear pulses and arm pulses, so that the following cases each give a different count: a decrement, a held count, a reload by clear, and a reload by timeout. It also includes a clear and a tick in the same cycle on the timeout step, which separates clear priority from a late timeout. Directed runs in armed mode send arm pulses during extended reset and clear pulses before start. These runs show whether the start condition ignores pulses at the wrong time. A run at initial value 511 checks that the full counter width is used, and a reset-only start checks auto mode when no extended reset is seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned WDT_CNT_W = 9;

    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_WAIT = 2'd1,
        WS_RUN  = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic hold;
        logic run;
        logic kick;
        logic tick;
    } wdt_ctl_t;

    function automatic logic arm_accepted(input logic auto_mode, input logic arm);
        return !auto_mode && arm;
    endfunction

    function automatic logic at_floor(input logic [31:0] value);
        return value <= 32'd1;
    endfunction

endpackage

// File: rtl/wdt_start_fsm.sv
module wdt_start_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_i,
    input  logic auto_start_i,
    input  logic arm_pulse_i,
    output logic running_o
);

    wdt_state_e state_q;
    wdt_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ext_rst_i) begin
            state_d = WS_HOLD;
        end else begin
            unique case (state_q)
                WS_HOLD: state_d = auto_start_i ? WS_RUN : WS_WAIT;
                WS_WAIT: if (arm_accepted(auto_start_i, arm_pulse_i)) state_d = WS_RUN;
                WS_RUN:  state_d = WS_RUN;
                default: state_d = WS_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WS_HOLD;
        else     state_q <= state_d;
    end

    assign running_o = (state_q == WS_RUN);

    // R1 / R4: extended reset always forces the stopped state
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        ext_rst_i |=> (state_q == WS_HOLD));

    // R2: auto mode leaves hold straight into counting
    p_auto_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_HOLD && !ext_rst_i && auto_start_i) |=> (state_q == WS_RUN));

    // R3: armed mode parks in wait after release
    p_park_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_HOLD && !ext_rst_i && !auto_start_i) |=> (state_q == WS_WAIT));

    // R3: waiting persists without an arm pulse
    p_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_WAIT && !ext_rst_i && !arm_pulse_i) |=> (state_q == WS_WAIT));

    // R3: an accepted arm pulse starts counting
    p_arm_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_WAIT && !ext_rst_i && !auto_start_i && arm_pulse_i) |=> (state_q == WS_RUN));

    // R9: once running, only extended reset stops it
    p_keep_run_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_RUN && !ext_rst_i) |=> (state_q == WS_RUN));

endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = WDT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wdt_ctl_t         ctl_i,
    input  logic [CNT_W-1:0] init_i,
    output logic [CNT_W-1:0] count_o,
    output logic             timeout_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             fire_q;
    logic             reload;
    logic             expire;

    assign reload = ctl_i.hold || !ctl_i.run || ctl_i.kick;
    assign expire = !reload && ctl_i.tick && at_floor(32'(cnt_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= init_i;
            fire_q <= 1'b0;
        end else begin
            fire_q <= expire;
            if (reload || expire) begin
                cnt_q <= init_i;
            end else if (ctl_i.tick) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign count_o   = cnt_q;
    assign timeout_o = fire_q;

    // R1: stopped counter sits at the initial value, no timeout
    p_idle_load_r1: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.run || ctl_i.hold) |=> (cnt_q == $past(init_i) && !fire_q));

    // R5: a tick above the floor decrements by one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && !ctl_i.hold && !ctl_i.kick && ctl_i.tick && cnt_q > 1)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: no tick, no change
    p_hold_cnt_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && !ctl_i.hold && !ctl_i.kick && !ctl_i.tick) |=> $stable(cnt_q));

    // R6: tick on the floor gives a pulse and a reload
    p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && !ctl_i.hold && !ctl_i.kick && ctl_i.tick && cnt_q <= 1)
        |=> (fire_q && cnt_q == $past(init_i)));

    // R7: clear wins over any tick
    p_kick_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.run && !ctl_i.hold && ctl_i.kick) |=> (!fire_q && cnt_q == $past(init_i)));

endmodule

// File: rtl/retrig_wdt.sv
module retrig_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = WDT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst_i,
    input  logic             tick_i,
    input  logic             auto_start_i,
    input  logic             arm_pulse_i,
    input  logic             kick_pulse_i,
    input  logic [CNT_W-1:0] init_val_i,
    output logic             timeout_o,
    output logic             running_o,
    output logic [CNT_W-1:0] count_o
);

    logic     run;
    wdt_ctl_t ctl;

    wdt_start_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ext_rst_i    (ext_rst_i),
        .auto_start_i (auto_start_i),
        .arm_pulse_i  (arm_pulse_i),
        .running_o    (run)
    );

    always_comb begin
        ctl.hold = ext_rst_i;
        ctl.run  = run;
        ctl.kick = kick_pulse_i;
        ctl.tick = tick_i;
    end

    wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .ctl_i     (ctl),
        .init_i    (init_val_i),
        .count_o   (count_o),
        .timeout_o (timeout_o)
    );

    assign running_o = run;

    // R8: a timeout only follows a running cycle
    p_no_idle_timeout_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !timeout_o);

endmodule

// File: tb/retrig_wdt_bench.sv
module retrig_wdt_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst = 1'b0;
    logic       tick = 1'b0;
    logic       auto_start = 1'b1;
    logic       arm = 1'b0;
    logic       kick = 1'b0;
    logic [8:0] init_val = 9'd3;
    logic       timeout;
    logic       running;
    logic [8:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    retrig_wdt u_retrig_wdt (
        .clk          (clk),
        .rst          (rst),
        .ext_rst_i    (ext_rst),
        .tick_i       (tick),
        .auto_start_i (auto_start),
        .arm_pulse_i  (arm),
        .kick_pulse_i (kick),
        .init_val_i   (init_val),
        .timeout_o    (timeout),
        .running_o    (running),
        .count_o      (count)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       ext, armp, kickp, tk;
        logic       e_run, e_to;
        logic [8:0] e_cnt;
    } vec_t;

    // auto mode, initial value 3; expected values are after the clock edge
    localparam vec_t TBL [16] = '{
        '{4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'd3},  // R1 tick ignored in hold
        '{4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd3},  // R1 arm ignored in hold
        '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd3},  // R2 auto start
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd2},  // R5 decrement
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd2},  // R5 hold without tick
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd1},
        '{4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 9'd3},  // R6 timeout and reload
        '{4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd3},  // R6 single cycle
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd2},
        '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'd3},  // R7 clear beats tick
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd2},
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'd1},
        '{4'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'd3},  // R7 clear beats timeout
        '{4'd9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'd2},  // R9 arm while running
        '{4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'd3},  // R1 stop on ext reset
        '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd3}   // R2 restart
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic a, input logic k, input logic t);
        ext_rst = e;
        arm     = a;
        kick    = k;
        tick    = t;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic r, input logic to, input logic [8:0] c);
        chk({tag, " running"}, {8'd0, running}, {8'd0, r});
        chk({tag, " timeout"}, {8'd0, timeout}, {8'd0, to});
        chk({tag, " count"}, count, c);
    endtask

    task automatic do_reset(input logic e);
        rst = 1'b1;
        step(e, 1'b0, 1'b0, 1'b0);
        step(e, 1'b0, 1'b0, 1'b1);
        expect_out("R1 reset", 1'b0, 1'b0, init_val);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all requirements: watchdog expired, actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // table walk, auto mode
        auto_start = 1'b1;
        init_val   = 9'd3;
        do_reset(1'b1);
        for (int i = 0; i < 16; i++) begin
            step(TBL[i].ext, TBL[i].armp, TBL[i].kickp, TBL[i].tk);
            expect_out($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].e_run, TBL[i].e_to, TBL[i].e_cnt);
        end

        // armed mode, initial value 5
        auto_start = 1'b0;
        init_val   = 9'd5;
        do_reset(1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0);
        expect_out("R4 arm in ext reset", 1'b0, 1'b0, 9'd5);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R4 after release", 1'b0, 1'b0, 9'd5);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            expect_out("R3 waiting for arm", 1'b0, 1'b0, 9'd5);
        end
        step(1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R8 clear before start", 1'b0, 1'b0, 9'd5);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R8 still stopped", 1'b0, 1'b0, 9'd5);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R3 armed", 1'b1, 1'b0, 9'd5);
        for (int i = 1; i <= 4; i++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            expect_out("R5 armed countdown", 1'b1, 1'b0, 9'(5 - i));
        end
        step(1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R6 fifth tick timeout", 1'b1, 1'b1, 9'd5);

        // full width, auto start from system reset alone
        auto_start = 1'b1;
        init_val   = 9'd511;
        do_reset(1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R2 start after reset", 1'b1, 1'b0, 9'd511);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        expect_out("R5 full width step", 1'b1, 1'b0, 9'd510);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        expect_out("R7 clear reload", 1'b1, 1'b0, 9'd511);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule